// File: doc/BRIEF.md
# Program-Cycle Status Read Logic

This block decides which byte a host read returns from a byte-wide non-volatile memory while the memory is busy with an internal program cycle. When no cycle is running, a read returns the array data unchanged. While a cycle is running, a read returns a status byte made of three independent end-of-write indications, and the low five bits are left undriven.

The three indications are as follows. Bit 7 is a data-polling bit that holds the inverse of bit 7 of the last byte written. Bit 6 is a toggle bit that starts at 0 and flips after every completed read. Bit 5 reports the page-load window: 0 while the window is still open and 1 once it has closed.

The block also drives an open-drain ready/busy indication. It is modelled as a pull-low enable that is active for the whole program cycle, with a pull-up assumed outside the block. Program timing, the array and the write path belong to neighbouring blocks. This block only sees a busy level, the polled data bit, the window status, the bus strobes and the array read data.

Top module: `psr_status_read`

## Requirements
- R1: After synchronous reset, with the bus idle, `dq_oe` is 0, `dq_out` is 0 and the toggle state is 0, so the first status read returns 0 in bit 6.
- R2: The data bus is driven only while `ce_n`=0, `oe_n`=0 and `we_n`=1. At any other time `dq_oe` is 0 and `dq_out` is 0.
- R3: During a read with `busy`=0, `dq_out` equals `array_data` and `dq_oe` is all ones.
- R4: During a read with `busy`=1, bit 7 of `dq_out` is the inverse of `last_poll_bit`.
- R5: During a program cycle, bit 6 is 0 on the first read. It flips when each read ends, where a read ends on the first clock at which the read condition of R2 is no longer true.
- R6: During a read with `busy`=1, bit 5 equals `plt_expired`: 0 while the load window runs and 1 after it has expired.
- R7: During a read with `busy`=1, bits 4 to 0 are undriven: `dq_oe` is 8'hE0, and `dq_out[4:0]` is 0.
- R8: `rb_pull_low` is 1 exactly while `busy` is 1. A value of 1 pulls the external ready/busy line low.
- R9: The toggle state returns to 0 when `busy` rises, even if a read ends in that same clock. After `busy` falls, toggling stops, and the first read of the next cycle returns 0 in bit 6.
- R10: During a read with `busy`=1, `array_data` has no effect on `dq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | Internal program cycle running |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| plt_expired | input | 1 | Page-load window closed |
| last_poll_bit | input | 1 | Bit 7 of the last byte written |
| array_data | input | DATA_W | Array read data |
| dq_out | output | DATA_W | Read data toward the bus |
| dq_oe | output | DATA_W | Per-bit output enable |
| rb_pull_low | output | 1 | Open-drain ready/busy pull-low enable |

## Verification
The toggle restart and the end of a read can fall in the same clock. This happens when a read that started while the memory was idle is released on the same clock at which `busy` rises. The bench provokes exactly that: it holds a read across the idle period, then deasserts `oe_n` and raises `busy` at the same negative edge. The next status read must return 0 in bit 6, which shows that the restart took priority over the flip.

// File: rtl/psr_pkg.sv
package psr_pkg;

    // Positions of the status bits within the returned byte
    localparam int POLL_BIT = 7;
    localparam int TOG_BIT  = 6;
    localparam int PLT_BIT  = 5;
    localparam int LOW_W    = PLT_BIT;

    typedef struct packed {
        logic poll;
        logic tog;
        logic plt;
    } status_t;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_ARRAY  = 2'd1,
        SRC_STATUS = 2'd2
    } rd_src_e;

    function automatic logic [7:0] status_byte(status_t s);
        logic [7:0] b;
        b           = '0;
        b[POLL_BIT] = s.poll;
        b[TOG_BIT]  = s.tog;
        b[PLT_BIT]  = s.plt;
        return b;
    endfunction

    function automatic logic [7:0] status_enable();
        logic [7:0] e;
        e           = '0;
        e[POLL_BIT] = 1'b1;
        e[TOG_BIT]  = 1'b1;
        e[PLT_BIT]  = 1'b1;
        return e;
    endfunction

endpackage

// File: rtl/psr_access_decode.sv
module psr_access_decode
    import psr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    busy,
    input  logic    ce_n,
    input  logic    oe_n,
    input  logic    we_n,
    output logic    rd_active,
    output logic    rd_end,
    output logic    busy_rise,
    output rd_src_e rd_src
);

    logic rd_q;
    logic busy_q;

    assign rd_active = !ce_n && !oe_n && we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q   <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            rd_q   <= rd_active;
            busy_q <= busy;
        end
    end

    assign rd_end    = rd_q && !rd_active;
    assign busy_rise = busy && !busy_q;

    always_comb begin
        if (!rd_active)
            rd_src = SRC_NONE;
        else if (busy)
            rd_src = SRC_STATUS;
        else
            rd_src = SRC_ARRAY;
    end

endmodule

// File: rtl/psr_toggle.sv
module psr_toggle (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic busy_rise,
    input  logic rd_end,
    output logic tog
);

    always_ff @(posedge clk) begin
        if (rst)
            tog <= 1'b0;
        else if (!busy || busy_rise)
            tog <= 1'b0;
        else if (rd_end)
            tog <= ~tog;
    end

    // R9: a new program cycle always restarts the toggle at 0
    a_r9_restart: assert property (@(posedge clk) disable iff (rst)
        busy_rise |=> (tog == 1'b0));

    // R5: a finished read inside a running cycle flips the toggle
    a_r5_flip: assert property (@(posedge clk) disable iff (rst)
        (busy && !busy_rise && rd_end) |=> (tog != $past(tog)));

    // R5: without a finished read the toggle holds
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !busy_rise && !rd_end && $past(busy)) |=> $stable(tog));

endmodule

// File: rtl/psr_status_mux.sv
module psr_status_mux
    import psr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  rd_src_e           rd_src,
    input  status_t           stat,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_oe
);

    localparam logic [7:0] STAT_EN = status_enable();

    logic [7:0] stat_b;
    assign stat_b = status_byte(stat);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i < 8) begin : g_stat
            always_comb begin
                unique case (rd_src)
                    SRC_ARRAY: begin
                        dq_out[i] = array_data[i];
                        dq_oe[i]  = 1'b1;
                    end
                    SRC_STATUS: begin
                        dq_out[i] = stat_b[i] & STAT_EN[i];
                        dq_oe[i]  = STAT_EN[i];
                    end
                    default: begin
                        dq_out[i] = 1'b0;
                        dq_oe[i]  = 1'b0;
                    end
                endcase
            end
        end else begin : g_wide
            always_comb begin
                dq_out[i] = (rd_src == SRC_ARRAY) ? array_data[i] : 1'b0;
                dq_oe[i]  = (rd_src == SRC_ARRAY);
            end
        end
    end

endmodule

// File: rtl/psr_status_read.sv
module psr_status_read
    import psr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              plt_expired,
    input  logic              last_poll_bit,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_oe,
    output logic              rb_pull_low
);

    logic    rd_active;
    logic    rd_end;
    logic    busy_rise;
    logic    tog;
    rd_src_e rd_src;
    status_t stat;

    psr_access_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .rd_active (rd_active),
        .rd_end    (rd_end),
        .busy_rise (busy_rise),
        .rd_src    (rd_src)
    );

    psr_toggle u_tog (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .busy_rise (busy_rise),
        .rd_end    (rd_end),
        .tog       (tog)
    );

    always_comb begin
        stat.poll = ~last_poll_bit;
        stat.tog  = tog;
        stat.plt  = plt_expired;
    end

    psr_status_mux #(.DATA_W(DATA_W)) u_mux (
        .rd_src     (rd_src),
        .stat       (stat),
        .array_data (array_data),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );

    // Open-drain ready/busy: pull low for the whole program cycle
    assign rb_pull_low = busy;

    // R2: the bus stays undriven outside a read access
    a_r2_quiet: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n || !we_n) |-> (dq_oe == '0));

    // R4: the polling bit carries the inverse of the last written bit 7
    a_r4_poll: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_active) |-> (dq_out[POLL_BIT] != last_poll_bit));

    // R7: the low bits float during a status read
    a_r7_low_float: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_active) |-> (dq_oe[LOW_W-1:0] == '0));

    // R6: bit 5 follows the load-window status during a status read
    a_r6_plt: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_active) |-> (dq_out[PLT_BIT] == plt_expired));

endmodule

// File: tb/psr_status_read_bench.sv
module psr_status_read_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       busy, ce_n, oe_n, we_n, plt_expired, last_poll_bit;
    logic [7:0] array_data, dq_out, dq_oe;
    logic       rb_pull_low;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    psr_status_read u_psr_status_read (
        .clk           (clk),
        .rst           (rst),
        .busy          (busy),
        .ce_n          (ce_n),
        .oe_n          (oe_n),
        .we_n          (we_n),
        .plt_expired   (plt_expired),
        .last_poll_bit (last_poll_bit),
        .array_data    (array_data),
        .dq_out        (dq_out),
        .dq_oe         (dq_oe),
        .rb_pull_low   (rb_pull_low)
    );

    // {busy, ce_n, oe_n, we_n, plt, last_bit7, array, exp_out, exp_oe}
    localparam int NV = 8;
    localparam logic [29:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 8'h3C, 8'hFF},
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h00, 8'h00},
        {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 8'h00, 8'h00},
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h00, 8'hE0},
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'hA0, 8'hE0},
        {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h55, 8'h80, 8'hE0},
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'hA5, 8'hA5, 8'hFF}
    };

    function automatic string vec_req(int i);
        case (i)
            0, 7:    return "R3 idle array read";
            1, 2, 5: return "R2 bus not driven";
            3:       return "R4 R7 polling and floating low bits";
            4:       return "R6 load-window bit";
            default: return "R10 array ignored while busy";
        endcase
    endfunction

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_idle();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    // One complete read: sample, then release and let the end register
    task automatic status_read(output logic [7:0] d, output logic [7:0] e);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        d = dq_out; e = dq_oe;
        @(negedge clk);
        oe_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, e;
        rst = 1'b1; busy = 1'b0; plt_expired = 1'b0; last_poll_bit = 1'b0;
        array_data = 8'h00;
        bus_idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check8("R1 dq_oe after reset", dq_oe, 8'h00);
        check8("R1 dq_out after reset", dq_out, 8'h00);
        check8("R8 rb idle after reset", {7'b0, rb_pull_low}, 8'h00);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            busy = 1'b0; bus_idle();
            @(negedge clk);
            busy          = VEC[i][29];
            plt_expired   = VEC[i][25];
            last_poll_bit = VEC[i][24];
            array_data    = VEC[i][23:16];
            @(negedge clk);
            @(negedge clk);
            ce_n = VEC[i][28]; oe_n = VEC[i][27]; we_n = VEC[i][26];
            #1;
            check8(vec_req(i), dq_out, VEC[i][15:8]);
            check8(vec_req(i), dq_oe, VEC[i][7:0]);
            check8("R8 rb follows busy", {7'b0, rb_pull_low}, {7'b0, VEC[i][29]});
            @(negedge clk);
            bus_idle();
        end

        // R5: toggle sequence 0,1,0,1 within one cycle
        @(negedge clk);
        busy = 1'b0; bus_idle(); plt_expired = 1'b0; last_poll_bit = 1'b1;
        array_data = 8'hC3;
        @(negedge clk);
        busy = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            status_read(d, e);
            check8("R5 toggle sequence", d, {1'b0, k[0], 6'b0});
        end

        // R10: array data change while busy does not alter the status
        array_data = 8'hFF;
        status_read(d, e);
        check8("R10 array ignored while busy", d, 8'h00);

        // R9: cycle ends, normal data returns, next cycle restarts at 0
        @(negedge clk);
        busy = 1'b0;
        array_data = 8'h5A;
        status_read(d, e);
        check8("R9 array data after cycle", d, 8'h5A);
        check8("R9 full drive after cycle", e, 8'hFF);
        @(negedge clk);
        busy = 1'b1;
        @(negedge clk);
        status_read(d, e);
        check8("R9 first read of new cycle", d, 8'h40 & 8'h00);
        status_read(d, e);
        check8("R5 second read of new cycle", d, 8'h40);

        // R9: read ends in the same clock that busy rises
        @(negedge clk);
        busy = 1'b0;
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        oe_n = 1'b1; busy = 1'b1;
        @(negedge clk);
        @(negedge clk);
        status_read(d, e);
        check8("R9 restart wins over read end", d, 8'h00);
        check8("R7 low bits floating", e, 8'hE0);

        // R6: window expires during the cycle
        plt_expired = 1'b1;
        status_read(d, e);
        check8("R6 expired window", d, 8'h60);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule